// File: doc/BRIEF.md
# Host-to-Microcontroller Command Mailbox

This block carries short commands from a host processor to an embedded display microcontroller through three registers. The host stores a 24-bit command (an opcode and two operand bytes) and a data word. It then sets a doorbell bit in the control register. That one bit carries the whole handshake: the host may set it, and only the consumer can clear it. A doorbell reading 0 tells the host that the consumer can take a new command.

When the doorbell goes from 0 to 1, the block copies the command and data into a consumer-side latch and raises a one-cycle command-valid strobe. It also decodes the opcode into a command kind and typed operands: level-set, pipe-select and backlight-set. Two special cases apply. A pipe-select that carries pipe index 255 is flagged as an immediate disable. A backlight-set aimed at controller 0 has its ramp value forced to zero.

Sticky flags in the control register record three events: writes that were dropped because the doorbell was set, opcodes that were not recognised, and a doorbell held for longer than a cycle limit. The host clears each flag by writing 1 to its bit.

Top module: `host_mcu_mailbox`

## Requirements
- R1: After reset the doorbell is 0, cmd_valid is 0, every sticky flag is 0, and the command register (address 0), data register (address 1) and control register (address 2) all read as 0.
- R2: While the doorbell is 0, a host write to address 0 stores wdata[23:0] as the command: opcode in bits 7:0, operand byte A in bits 15:8, operand byte B in bits 23:16. A host write to address 1 stores the data word. Both registers read back what was written.
- R3: A host write to address 2 with bit 0 set, while the doorbell is 0, sets the doorbell (control bit 0). In the next cycle cmd_valid is 1 for exactly one cycle, and the command and data registers are latched onto the consumer outputs.
- R4: Only mcu_done clears the doorbell. A host write of 0 to control bit 0 leaves it at 1. While cmd_valid is low, the consumer outputs hold their values for as long as the doorbell stays set.
- R5: While the doorbell is 1, host writes to addresses 0 and 1 are dropped and set the sticky write-error flag (control bit 1).
- R6: cmd_kind decodes the latched opcode as follows: 0x65 gives 1 (level-set), 0x66 gives 2 (pipe-select), 0x67 gives 3 (backlight-set), and any other opcode gives 0. cmd_pipe carries operand byte A, cmd_level carries operand byte B, and cmd_data carries the data word (the ramping boundary for a pipe-select).
- R7: cmd_imm_disable is 1 exactly when cmd_kind is 2 and cmd_pipe is 255.
- R8: For a backlight-set with operand byte A equal to 0, cmd_data (the frame ramp) is 0. For any other command, cmd_data equals the data register.
- R9: An unrecognised opcode still produces the cmd_valid strobe and is cleared by mcu_done like any other command, and it sets the sticky unknown-opcode flag (control bit 2).
- R10: If the doorbell stays at 1 for TIMEOUT_CYCLES clock edges after the edge that set it, the sticky timeout flag (control bit 3) becomes 1 at that edge. It does not become 1 one edge earlier.
- R11: Writing 1 to control bit 1, 2 or 3 clears that sticky flag. Writing 0 to those bits leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write enable |
| host_addr | input | 2 | Host register address: 0 command, 1 data, 2 control |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data (combinational on host_addr) |
| mcu_done | input | 1 | Consumer finished the command; clears the doorbell |
| db_busy | output | 1 | Doorbell state |
| cmd_valid | output | 1 | One-cycle strobe when a new command is latched |
| cmd_kind | output | 2 | Decoded command kind |
| cmd_pipe | output | 8 | Operand byte A (controller index) |
| cmd_level | output | 8 | Operand byte B (level value) |
| cmd_imm_disable | output | 1 | Pipe-select carrying the immediate-disable index |
| cmd_data | output | DATA_W | Latched data word (boundary or frame ramp) |

## Verification
The bench builds the block with DATA_W at 32 and TIMEOUT_CYCLES lowered to 16. The short limit lets a test step through the timeout edge by edge: the flag must still be clear one edge before the limit and must be set exactly at it. The full opcode byte is swept over all 256 values, with operand bytes derived from each opcode, so every decode path and the unknown-opcode flag are exercised. Operand byte A is also swept over all 256 values for both pipe-select and backlight-set, which reaches the immediate-disable index and the zero-ramp case for controller 0.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic [1:0] {
      KIND_OTHER     = 2'd0,
      KIND_LEVEL     = 2'd1,
      KIND_PIPE      = 2'd2,
      KIND_BACKLIGHT = 2'd3
   } mbx_kind_e;

   localparam logic [7:0] OPC_LEVEL     = 8'h65;
   localparam logic [7:0] OPC_PIPE      = 8'h66;
   localparam logic [7:0] OPC_BACKLIGHT = 8'h67;

   localparam logic [1:0] ADR_CMD  = 2'd0;
   localparam logic [1:0] ADR_DATA = 2'd1;
   localparam logic [1:0] ADR_CTRL = 2'd2;

   localparam int CTL_DB  = 0;
   localparam int CTL_ERR = 1;
   localparam int CTL_UNK = 2;
   localparam int CTL_TMO = 3;

   localparam int CMD_W = 24;

   function automatic mbx_kind_e classify(input logic [7:0] opc);
      case (opc)
         OPC_LEVEL:     classify = KIND_LEVEL;
         OPC_PIPE:      classify = KIND_PIPE;
         OPC_BACKLIGHT: classify = KIND_BACKLIGHT;
         default:       classify = KIND_OTHER;
      endcase
   endfunction
endpackage

// File: rtl/mbx_timeout.sv
module mbx_timeout #(
   parameter int LIMIT = 80000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   output logic hit
);
   localparam int CNT_W = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!busy)
         cnt_q <= '0;
      else if (cnt_q != LAST)
         cnt_q <= cnt_q + 1'b1;
   end

   assign hit = busy && (cnt_q == LAST);
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
   import mbx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              done,
   input  logic              tmo_hit,
   output logic [DATA_W-1:0] rdata,
   output logic              db,
   output logic              strobe,
   output logic [CMD_W-1:0]  lat_cmd,
   output logic [DATA_W-1:0] lat_data
);
   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] data_q;
   logic              err_q, unk_q, tmo_q;

   logic wr_ctrl, ring, dropped;
   logic [3:0] clr;

   assign wr_ctrl = we && (addr == ADR_CTRL);
   assign ring    = wr_ctrl && wdata[CTL_DB] && !db;
   assign dropped = we && db && (addr == ADR_CMD || addr == ADR_DATA);
   assign clr     = wr_ctrl ? wdata[3:0] : 4'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         data_q   <= '0;
         db       <= 1'b0;
         strobe   <= 1'b0;
         lat_cmd  <= '0;
         lat_data <= '0;
         err_q    <= 1'b0;
         unk_q    <= 1'b0;
         tmo_q    <= 1'b0;
      end else begin
         if (we && !db && addr == ADR_CMD)  cmd_q  <= wdata[CMD_W-1:0];
         if (we && !db && addr == ADR_DATA) data_q <= wdata;
         if (db) begin
            if (done) db <= 1'b0;
         end else if (ring) begin
            db <= 1'b1;
         end
         strobe <= ring;
         if (ring) begin
            lat_cmd  <= cmd_q;
            lat_data <= data_q;
         end
         err_q <= (err_q && !clr[CTL_ERR]) || dropped;
         unk_q <= (unk_q && !clr[CTL_UNK]) ||
                  (ring && classify(cmd_q[7:0]) == KIND_OTHER);
         tmo_q <= (tmo_q && !clr[CTL_TMO]) || tmo_hit;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADR_CMD:  rdata[CMD_W-1:0] = cmd_q;
         ADR_DATA: rdata = data_q;
         ADR_CTRL: rdata[3:0] = {tmo_q, unk_q, err_q, db};
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
   import mbx_pkg::*;
#(
   parameter int          DATA_W         = 32,
   parameter logic [7:0]  PIPE_OFF       = 8'hFF,
   parameter bit          ZERO_RAMP_IDX0 = 1'b1
) (
   input  logic [CMD_W-1:0]  lat_cmd,
   input  logic [DATA_W-1:0] lat_data,
   output mbx_kind_e         kind,
   output logic [7:0]        pipe,
   output logic [7:0]        level,
   output logic              imm_dis,
   output logic [DATA_W-1:0] data
);
   assign kind    = classify(lat_cmd[7:0]);
   assign pipe    = lat_cmd[15:8];
   assign level   = lat_cmd[23:16];
   assign imm_dis = (kind == KIND_PIPE) && (pipe == PIPE_OFF);

   generate
      if (ZERO_RAMP_IDX0) begin : g_ramp_gate
         assign data = (kind == KIND_BACKLIGHT && pipe == 8'd0) ? '0 : lat_data;
      end else begin : g_ramp_pass
         assign data = lat_data;
      end
   endgenerate
endmodule

// File: rtl/host_mcu_mailbox.sv
module host_mcu_mailbox
   import mbx_pkg::*;
#(
   parameter int         DATA_W         = 32,
   parameter int         TIMEOUT_CYCLES = 80000,
   parameter logic [7:0] PIPE_OFF       = 8'hFF,
   parameter bit         ZERO_RAMP_IDX0 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              mcu_done,
   output logic              db_busy,
   output logic              cmd_valid,
   output logic [1:0]        cmd_kind,
   output logic [7:0]        cmd_pipe,
   output logic [7:0]        cmd_level,
   output logic              cmd_imm_disable,
   output logic [DATA_W-1:0] cmd_data
);
   generate
      if (DATA_W < CMD_W) begin : g_bad_width
         $error("DATA_W must hold the 24-bit command");
      end
      if (TIMEOUT_CYCLES < 2) begin : g_bad_limit
         $error("TIMEOUT_CYCLES must be at least 2");
      end
   endgenerate

   logic              tmo_hit;
   logic [CMD_W-1:0]  lat_cmd;
   logic [DATA_W-1:0] lat_data;
   mbx_kind_e         kind;

   mbx_regs #(.DATA_W(DATA_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (host_we),
      .addr     (host_addr),
      .wdata    (host_wdata),
      .done     (mcu_done),
      .tmo_hit  (tmo_hit),
      .rdata    (host_rdata),
      .db       (db_busy),
      .strobe   (cmd_valid),
      .lat_cmd  (lat_cmd),
      .lat_data (lat_data)
   );

   mbx_timeout #(.LIMIT(TIMEOUT_CYCLES)) tmo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (db_busy),
      .hit   (tmo_hit)
   );

   mbx_decode #(
      .DATA_W         (DATA_W),
      .PIPE_OFF       (PIPE_OFF),
      .ZERO_RAMP_IDX0 (ZERO_RAMP_IDX0)
   ) dec_i (
      .lat_cmd  (lat_cmd),
      .lat_data (lat_data),
      .kind     (kind),
      .pipe     (cmd_pipe),
      .level    (cmd_level),
      .imm_dis  (cmd_imm_disable),
      .data     (cmd_data)
   );

   assign cmd_kind = kind;
endmodule

// File: rtl/host_mcu_mailbox_chk.sv
module host_mcu_mailbox_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mcu_done,
   input logic              db_busy,
   input logic              cmd_valid,
   input logic [1:0]        cmd_kind,
   input logic [7:0]        cmd_pipe,
   input logic [7:0]        cmd_level,
   input logic              cmd_imm_disable,
   input logic [DATA_W-1:0] cmd_data
);
   AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> db_busy && !$past(db_busy)); // R3
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R3
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      db_busy && mcu_done |=> !db_busy); // R4
   AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      db_busy && !mcu_done |=> db_busy); // R4
   AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      db_busy && !cmd_valid |-> $stable(cmd_pipe) && $stable(cmd_level) && $stable(cmd_data)); // R4
   AST_IMM_ONLY_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_imm_disable |-> cmd_kind == 2'd2 && cmd_pipe == 8'hFF); // R7
endmodule

bind host_mcu_mailbox host_mcu_mailbox_chk #(.DATA_W(DATA_W)) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .mcu_done        (mcu_done),
   .db_busy         (db_busy),
   .cmd_valid       (cmd_valid),
   .cmd_kind        (cmd_kind),
   .cmd_pipe        (cmd_pipe),
   .cmd_level       (cmd_level),
   .cmd_imm_disable (cmd_imm_disable),
   .cmd_data        (cmd_data)
);

// File: tb/host_mcu_mailbox_tb_top.sv
module host_mcu_mailbox_tb_top;
   localparam int DW  = 32;
   localparam int TMO = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_we = 1'b0;
   logic [1:0]    host_addr = 2'd0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic          mcu_done = 1'b0;
   logic          db_busy, cmd_valid, cmd_imm_disable;
   logic [1:0]    cmd_kind;
   logic [7:0]    cmd_pipe, cmd_level;
   logic [DW-1:0] cmd_data;

   int n_chk = 0;
   int n_bad = 0;
   logic exp_unk = 1'b0;

   always #2 clk = ~clk;

   host_mcu_mailbox #(.DATA_W(DW), .TIMEOUT_CYCLES(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mcu_done(mcu_done),
      .db_busy(db_busy), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
      .cmd_pipe(cmd_pipe), .cmd_level(cmd_level),
      .cmd_imm_disable(cmd_imm_disable), .cmd_data(cmd_data)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic done_pulse();
      @(negedge clk); mcu_done = 1'b1;
      @(negedge clk); mcu_done = 1'b0;
   endtask

   // issue one command, check strobe and decoded outputs, then complete it
   task automatic issue(input string req, input logic [7:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic [DW-1:0] d);
      logic [1:0]    ek;
      logic [DW-1:0] ed, r;
      ek = (op == 8'h65) ? 2'd1 : (op == 8'h66) ? 2'd2 : (op == 8'h67) ? 2'd3 : 2'd0;
      ed = (ek == 2'd3 && a == 8'd0) ? '0 : d;
      wr(2'd0, {8'h00, b, a, op});
      wr(2'd1, d);
      wr(2'd2, 32'h1);
      if (ek == 2'd0) exp_unk = 1'b1;
      chk({req, " strobe/kind/pipe/level/imm"},
          {51'd0, cmd_valid, cmd_kind, cmd_pipe, cmd_level, cmd_imm_disable},
          {51'd0, 1'b1, ek, a, b, (ek == 2'd2 && a == 8'hFF)});
      chk({req, " data"}, {32'd0, cmd_data}, {32'd0, ed});
      @(negedge clk);
      chk({req, " strobe one cycle"}, {62'd0, cmd_valid, db_busy}, {62'd0, 2'b01});
      done_pulse();
      rd(2'd2, r);
      chk({req, " R9 unk flag / doorbell clear"}, {60'd0, r[3:0]}, {60'd0, 1'b0, exp_unk, 2'b00});
   endtask

   initial begin
      logic [DW-1:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, r); chk("R1 cmd reg", {32'd0, r}, 64'd0);
      rd(2'd1, r); chk("R1 data reg", {32'd0, r}, 64'd0);
      rd(2'd2, r); chk("R1 ctrl reg", {32'd0, r}, 64'd0);
      chk("R1 strobe", {63'd0, cmd_valid}, 64'd0);

      // R2 write/readback
      wr(2'd0, 32'hFF_C3B2A1);
      rd(2'd0, r); chk("R2 cmd readback", {32'd0, r}, {40'd0, 24'hC3B2A1});
      wr(2'd1, 32'hDEAD_BEEF);
      rd(2'd1, r); chk("R2 data readback", {32'd0, r}, {32'd0, 32'hDEAD_BEEF});

      // R3 ring, R4 host cannot clear, R5 dropped writes
      wr(2'd0, 32'h00_0366);
      wr(2'd1, 32'h0000_FFFF);
      wr(2'd2, 32'h1);
      chk("R3 strobe and pipe", {55'd0, cmd_valid, cmd_pipe}, {55'd0, 1'b1, 8'h03});
      chk("R6 boundary data", {32'd0, cmd_data}, {32'd0, 32'h0000_FFFF});
      wr(2'd2, 32'h0);
      chk("R4 host write 0 keeps doorbell", {63'd0, db_busy}, 64'd1);
      wr(2'd1, 32'h1111_2222);
      wr(2'd0, 32'h00_0067);
      rd(2'd1, r); chk("R5 data unchanged", {32'd0, r}, {32'd0, 32'h0000_FFFF});
      rd(2'd0, r); chk("R5 cmd unchanged", {32'd0, r}, {40'd0, 24'h000366});
      rd(2'd2, r); chk("R5 err flag", {60'd0, r[3:0]}, {60'd0, 4'b0011});
      chk("R4 outputs held", {48'd0, cmd_data[15:0], cmd_pipe, cmd_level}, {48'd0, 16'hFFFF, 8'h03, 8'h00});
      done_pulse();
      chk("R4 done clears", {63'd0, db_busy}, 64'd0);
      wr(2'd2, 32'h0);
      rd(2'd2, r); chk("R11 write 0 keeps err", {60'd0, r[3:0]}, {60'd0, 4'b0010});
      wr(2'd2, 32'h2);
      rd(2'd2, r); chk("R11 W1C err", {60'd0, r[3:0]}, 64'd0);

      // R6 R9 sweep of all opcodes
      for (int op = 0; op < 256; op++)
         issue("R6", 8'(op), 8'(op) ^ 8'h5A, ~8'(op), {8'(op), 8'h3C, 8'(op), 8'hC3});

      // R7 R8 sweep of operand byte A for pipe-select and backlight-set
      for (int a = 0; a < 256; a++) begin
         issue("R7", 8'h66, 8'(a), 8'h10, 32'h0000_FFFF);
         issue("R8", 8'h67, 8'(a), 8'h20, 32'h0000_0040 + 32'(a));
      end

      // R11 clear unknown flag
      wr(2'd2, 32'h4); exp_unk = 1'b0;
      rd(2'd2, r); chk("R11 W1C unk", {60'd0, r[3:0]}, 64'd0);

      // R10 timeout boundary
      wr(2'd2, 32'h1);
      repeat (TMO - 1) @(negedge clk);
      rd(2'd2, r); chk("R10 no flag one edge early", {60'd0, r[3:0]}, {60'd0, 4'b0001});
      @(negedge clk);
      rd(2'd2, r); chk("R10 flag at limit", {60'd0, r[3:0]}, {60'd0, 4'b1001});
      done_pulse();
      wr(2'd2, 32'h8);
      rd(2'd2, r); chk("R11 W1C timeout", {60'd0, r[3:0]}, 64'd0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule